// File: doc/BRIEF.md
# UART Interrupt Identification and Request Merger

This block collects the interrupt causes of a 16550-style serial port and turns them into two things that software and the interrupt controller see: an identification byte, read by the CPU to learn which cause to service first, and a single request line. Each of the five causes (line error, receive timeout, receive data, transmit empty, modem status) reaches the block as a set pulse and a clear pulse from the logic that owns it. The block keeps one pending flag per cause and masks the flags with the enable register. It picks the most urgent enabled cause and encodes it.

Three behaviours go beyond a plain priority encoder. The receive-timeout cause has no enable bit of its own: it is enabled along with receive data when the FIFOs are on. Enabling the transmit-empty cause while the transmit FIFO is empty raises that interrupt again. Reading the identification byte while it reports transmit-empty acknowledges that cause. The request line is only driven when the modem-control output gate is set.

Top module: `uart_irq_ident`

## Requirements
- R1: After reset the identification byte reads 0x01, the enable register reads 0x00 and `irq` is 0.
- R2: Bits [3:1] of the identification byte encode the reported cause: line error 011 (byte 0x06), receive timeout 110 (0x0C), receive data 010 (0x04), transmit empty 001 (0x02), modem status 000 (0x00). Bit 0 is 1 only when no enabled cause is pending.
- R3: When several enabled causes are pending, the reported cause is the first of: line error, receive timeout, receive data, transmit empty, modem status.
- R4: An enable-register write stores bits [3:0] (bit 0 receive data, bit 1 transmit empty, bit 2 line error, bit 3 modem status). Bits [7:4] always read as 0.
- R5: The receive-timeout cause is enabled only if, at the last enable-register write, `fifo_en` was 1 and bit 0 was written as 1.
- R6: An enable-register write with bit 1 set while `tx_fifo_empty` is 1 makes transmit-empty pending in the next cycle. The same write with `tx_fifo_empty` at 0 does not.
- R7: A read of the identification byte in a cycle where it shows transmit-empty clears that pending flag. A read that shows any other code leaves transmit-empty pending.
- R8: With `fifo_en` at 1, bits [7:6] of the identification byte read 11. Otherwise they read 00. Bits [5:4] always read 0.
- R9: With `out2` at 0, `irq_oe` and `irq` are 0. With `out2` at 1, `irq_oe` is 1 and `irq` is 1 exactly when some enabled cause is pending.
- R10: A set pulse and a clear pulse for the same cause in the same cycle leave that cause pending.
- R11: A disabled cause stays pending and is reported as soon as it is enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_set | input | 5 | Set pulses, index 0 rx data, 1 tx empty, 2 line error, 3 modem status, 4 rx timeout |
| src_clr | input | 5 | Clear pulses, same indexing |
| ier_wr | input | 1 | Enable-register write strobe |
| ier_wdata | input | 8 | Enable-register write data |
| ier_rdata | output | 8 | Enable-register read value |
| iir_rd | input | 1 | Identification-byte read strobe |
| iir_rdata | output | 8 | Identification byte |
| fifo_en | input | 1 | FIFO mode is active |
| tx_fifo_empty | input | 1 | Transmit FIFO holds no data |
| out2 | input | 1 | Modem-control gate for the request line |
| irq | output | 1 | Interrupt request level |
| irq_oe | output | 1 | Drive enable for the request line; 0 means tristate, pulled inactive |

## Verification
The bench sets all causes at once and removes them one by one. A reversed or shifted priority chain then reports the wrong code at some step. It writes the enable register with FIFOs off and then on, and checks that a timeout only surfaces in the second case. A design that tied the timeout enable to the live FIFO state, or stored it with its own bit, would report it too early or not at all. It reads the identification byte both while it shows transmit-empty and while it shows something else, and enables transmit-empty with the FIFO full and empty. A design that acknowledged on every read, or re-armed regardless of the FIFO, loses or invents a transmit interrupt. Random bursts of colliding set and clear pulses, gate toggles and reads are compared each cycle against a bench model.

// File: rtl/uirq_pkg.sv
// Shared constants for the UART interrupt identifier.
// Cause indices match the enable-register bit order for the four
// programmable causes; the receive timeout takes the extra index.
package uirq_pkg;
    localparam int NSRC      = 5;
    localparam int EN_W      = 4;
    localparam int IDX_RXD   = 0;
    localparam int IDX_THRE  = 1;
    localparam int IDX_LINE  = 2;
    localparam int IDX_MODEM = 3;
    localparam int IDX_RXTO  = 4;

    typedef enum logic [2:0] {
        ID_MODEM = 3'b000,
        ID_THRE  = 3'b001,
        ID_RXD   = 3'b010,
        ID_LINE  = 3'b011,
        ID_RXTO  = 3'b110
    } id_code_e;

    // Causes from most to least urgent.
    localparam int PRIO [NSRC] = '{IDX_LINE, IDX_RXTO, IDX_RXD, IDX_THRE, IDX_MODEM};

    // Identification code for one cause index.
    function automatic id_code_e code_of(input int idx);
        case (idx)
            IDX_LINE: return ID_LINE;
            IDX_RXTO: return ID_RXTO;
            IDX_RXD:  return ID_RXD;
            IDX_THRE: return ID_THRE;
            default:  return ID_MODEM;
        endcase
    endfunction
endpackage

// File: rtl/uirq_pend_bank.sv
// Pending flags, one per cause.
// Assumes set and clear are single-cycle pulses; set wins a collision.
module uirq_pend_bank #(
    parameter int NSRC = 5
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] set_i,
    input  logic [NSRC-1:0] clr_i,
    output logic [NSRC-1:0] pend_o
);
    for (genvar g = 0; g < NSRC; g++) begin : g_flag
        // Hold, set or clear one flag; set has precedence.
        always_ff @(posedge clk) begin
            if (!rst_n)
                pend_o[g] <= 1'b0;
            else if (set_i[g])
                pend_o[g] <= 1'b1;
            else if (clr_i[g])
                pend_o[g] <= 1'b0;
        end
    end
endmodule

// File: rtl/uirq_enable_reg.sv
// Interrupt enable register with the implied receive-timeout enable.
// Assumes fifo_en is sampled only when the register is written.
module uirq_enable_reg #(
    parameter int EN_W   = 4,
    parameter int DATA_W = 8,
    parameter int RXD_BIT = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              fifo_en_i,
    output logic [EN_W-1:0]   en_o,
    output logic              en_to_o,
    output logic [DATA_W-1:0] rdata_o
);
    localparam int PAD_W = DATA_W - EN_W;

    // Store the low enable bits and derive the timeout enable on write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_o    <= '0;
            en_to_o <= 1'b0;
        end else if (wr_i) begin
            en_o    <= wdata_i[EN_W-1:0];
            en_to_o <= fifo_en_i & wdata_i[RXD_BIT];
        end
    end

    // Read value: stored bits, upper bits zero.
    always_comb rdata_o = {{PAD_W{1'b0}}, en_o};
endmodule

// File: rtl/uirq_id_encode.sv
// Priority encoder producing the identification byte.
// Assumes the input is already masked by the enables.
module uirq_id_encode #(
    parameter int DATA_W = 8
) (
    input  logic [uirq_pkg::NSRC-1:0] masked_i,
    input  logic                      fifo_en_i,
    output logic [DATA_W-1:0]         id_o,
    output logic                      any_o,
    output logic                      is_thre_o
);
    import uirq_pkg::*;

    id_code_e code;

    // Walk from least to most urgent so the most urgent match remains.
    always_comb begin
        code = ID_MODEM;
        for (int k = NSRC - 1; k >= 0; k--) begin
            if (masked_i[PRIO[k]])
                code = code_of(PRIO[k]);
        end
    end

    // Assemble the byte: FIFO status, zero gap, code, no-pending flag.
    always_comb begin
        any_o     = |masked_i;
        is_thre_o = any_o && (code == ID_THRE);
        id_o      = '0;
        id_o[7:6] = {2{fifo_en_i}};
        id_o[3:1] = any_o ? code : 3'b000;
        id_o[0]   = ~any_o;
    end
endmodule

// File: rtl/uart_irq_ident.sv
// UART interrupt identifier: pending flags, enables, priority code, IRQ.
// Assumes callers pulse set/clear for one cycle and read strobes last
// one cycle; iir_rdata is valid combinationally in the read cycle.
module uart_irq_ident #(
    parameter int DATA_W = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [uirq_pkg::NSRC-1:0] src_set,
    input  logic [uirq_pkg::NSRC-1:0] src_clr,
    input  logic                      ier_wr,
    input  logic [DATA_W-1:0]         ier_wdata,
    output logic [DATA_W-1:0]         ier_rdata,
    input  logic                      iir_rd,
    output logic [DATA_W-1:0]         iir_rdata,
    input  logic                      fifo_en,
    input  logic                      tx_fifo_empty,
    input  logic                      out2,
    output logic                      irq,
    output logic                      irq_oe
);
    import uirq_pkg::*;

    localparam logic [NSRC-1:0] THRE_MASK = {{(NSRC-1){1'b0}}, 1'b1} << IDX_THRE;

    logic [NSRC-1:0] pend, masked, set_all, clr_all;
    logic [EN_W-1:0] en;
    logic            en_to, any_pend, is_thre, thre_rearm, thre_ack;

    uirq_enable_reg #(
        .EN_W(EN_W), .DATA_W(DATA_W), .RXD_BIT(IDX_RXD)
    ) u_en (
        .clk(clk), .rst_n(rst_n), .wr_i(ier_wr), .wdata_i(ier_wdata),
        .fifo_en_i(fifo_en), .en_o(en), .en_to_o(en_to), .rdata_o(ier_rdata)
    );

    // Extra set/clear terms for transmit-empty: re-arm and read acknowledge.
    always_comb begin
        thre_rearm = ier_wr & ier_wdata[IDX_THRE] & tx_fifo_empty;
        thre_ack   = iir_rd & is_thre;
        set_all    = src_set | (thre_rearm ? THRE_MASK : '0);
        clr_all    = src_clr | (thre_ack   ? THRE_MASK : '0);
    end

    uirq_pend_bank #(.NSRC(NSRC)) u_pend (
        .clk(clk), .rst_n(rst_n), .set_i(set_all), .clr_i(clr_all), .pend_o(pend)
    );

    // Mask pending flags with stored and implied enables.
    always_comb masked = pend & {en_to, en};

    uirq_id_encode #(.DATA_W(DATA_W)) u_enc (
        .masked_i(masked), .fifo_en_i(fifo_en),
        .id_o(iir_rdata), .any_o(any_pend), .is_thre_o(is_thre)
    );

    // Request line: driven only while the output gate is set.
    always_comb begin
        irq_oe = out2;
        irq    = out2 & any_pend;
    end
endmodule

// File: rtl/uirq_checker.sv
// Port-level properties of uart_irq_ident, attached by bind.
module uirq_checker #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [4:0]        src_set,
    input logic [4:0]        src_clr,
    input logic              ier_wr,
    input logic [DATA_W-1:0] ier_wdata,
    input logic [DATA_W-1:0] ier_rdata,
    input logic              iir_rd,
    input logic [DATA_W-1:0] iir_rdata,
    input logic              fifo_en,
    input logic              tx_fifo_empty,
    input logic              out2,
    input logic              irq,
    input logic              irq_oe
);
    AST_IER_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        ier_rdata[DATA_W-1:4] == '0); // R4

    AST_IER_STORE: assert property (@(posedge clk) disable iff (!rst_n)
        ier_wr |=> ier_rdata[3:0] == $past(ier_wdata[3:0])); // R4

    AST_FIFO_BITS: assert property (@(posedge clk) disable iff (!rst_n)
        iir_rdata[7:4] == {{2{fifo_en}}, 2'b00}); // R8

    AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        !out2 |-> (!irq && !irq_oe)); // R9

    AST_IRQ_MATCHES_ID: assert property (@(posedge clk) disable iff (!rst_n)
        out2 |-> (irq == !iir_rdata[0])); // R9

    AST_THRE_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        (iir_rd && iir_rdata[3:0] == 4'h2 && !src_set[1] &&
         !(ier_wr && ier_wdata[1] && tx_fifo_empty)) |=> iir_rdata[3:0] != 4'h2); // R7

    AST_LINE_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (src_set[2] && ier_rdata[2] && !ier_wr) |=> iir_rdata[3:0] == 4'h6); // R10
endmodule

bind uart_irq_ident uirq_checker #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/tb_uart_irq_ident.sv
module tb_uart_irq_ident;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [4:0] src_set = '0, src_clr = '0;
    logic       ier_wr = 1'b0;
    logic [7:0] ier_wdata = '0;
    logic [7:0] ier_rdata;
    logic       iir_rd = 1'b0;
    logic [7:0] iir_rdata;
    logic       fifo_en = 1'b0, tx_fifo_empty = 1'b0, out2 = 1'b0;
    logic       irq, irq_oe;

    int checks = 0, errors = 0;
    bit done = 0;

    // Bench model state.
    logic [4:0] m_pend = '0;
    logic [3:0] m_en = '0;
    logic       m_to = 1'b0;

    always #5 clk = ~clk;

    uart_irq_ident dut (.*);

    // Expected identification byte from the requirement tables.
    function automatic logic [7:0] exp_iir(logic [4:0] p, logic [3:0] e, logic t, logic f);
        logic [4:0] m = p & {t, e};
        logic [7:0] v;
        if      (m[2]) v = 8'h06;
        else if (m[4]) v = 8'h0C;
        else if (m[0]) v = 8'h04;
        else if (m[1]) v = 8'h02;
        else if (m[3]) v = 8'h00;
        else           v = 8'h01;
        return v | (f ? 8'hC0 : 8'h00);
    endfunction

    task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual 0x%02h expected 0x%02h at %0t", tag, act, exp, $time);
        end
    endtask

    // One cycle: drive at the falling edge, check, advance the model.
    task automatic cyc(string tag, logic [4:0] s, logic [4:0] c, logic w, logic [7:0] wd,
                       logic rd, logic f, logic txe, logic o2);
        logic [7:0] e_iir;
        logic [4:0] s_eff, c_eff;
        @(negedge clk);
        src_set = s; src_clr = c; ier_wr = w; ier_wdata = wd;
        iir_rd = rd; fifo_en = f; tx_fifo_empty = txe; out2 = o2;
        #1;
        e_iir = exp_iir(m_pend, m_en, m_to, f);
        check(tag, iir_rdata, e_iir);
        check("R4", ier_rdata, {4'h0, m_en});
        check("R9", {6'b0, irq_oe, irq}, {6'b0, o2, o2 & ~e_iir[0]});
        s_eff = s | ((w && wd[1] && txe) ? 5'b00010 : 5'b0);
        c_eff = c | ((rd && e_iir[3:0] == 4'h2) ? 5'b00010 : 5'b0);
        @(posedge clk);
        m_pend = s_eff | (m_pend & ~c_eff);
        if (w) begin m_en = wd[3:0]; m_to = f & wd[0]; end
    endtask

    task automatic idle(string tag, logic f, logic o2);
        cyc(tag, 5'b0, 5'b0, 1'b0, 8'h00, 1'b0, f, 1'b0, o2);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        // R1: reset values.
        @(negedge clk); #1;
        check("R1", iir_rdata, 8'h01);
        check("R1", ier_rdata, 8'h00);
        check("R1", {7'b0, irq}, 8'h00);

        // R4: only low nibble stored.
        cyc("R4", 5'b0, 5'b0, 1'b1, 8'hFF, 1'b0, 1'b0, 1'b0, 1'b1);
        @(negedge clk); #1 check("R4", ier_rdata, 8'h0F);

        // R2/R3: all causes pending, FIFOs off, so timeout stays masked.
        cyc("R3", 5'b11111, 5'b0, 1'b0, 8'h0, 1'b0, 1'b0, 1'b0, 1'b1);
        @(negedge clk); #1 check("R3", iir_rdata, 8'h06);
        cyc("R2", 5'b0, 5'b00100, 1'b0, 8'h0, 1'b0, 1'b0, 1'b0, 1'b1);
        @(negedge clk); #1 check("R5", iir_rdata, 8'h04);
        cyc("R2", 5'b0, 5'b00001, 1'b0, 8'h0, 1'b0, 1'b0, 1'b0, 1'b1);
        @(negedge clk); #1 check("R2", iir_rdata, 8'h02);
        // R7: read showing tx acknowledges it.
        cyc("R7", 5'b0, 5'b0, 1'b0, 8'h0, 1'b1, 1'b0, 1'b0, 1'b1);
        @(negedge clk); #1 check("R7", iir_rdata, 8'h00);
        cyc("R2", 5'b0, 5'b01000, 1'b0, 8'h0, 1'b0, 1'b0, 1'b0, 1'b1);
        @(negedge clk); #1 check("R11", iir_rdata, 8'h01);
        // R5/R11/R8: enable with FIFOs on exposes the held timeout.
        cyc("R5", 5'b0, 5'b0, 1'b1, 8'h01, 1'b0, 1'b1, 1'b0, 1'b1);
        @(negedge clk); #1 check("R5", iir_rdata, 8'hCC);
        check("R8", {7'b0, irq}, 8'h01);
        cyc("R5", 5'b0, 5'b10000, 1'b0, 8'h0, 1'b0, 1'b1, 1'b0, 1'b1);
        // R6: re-arm only with the transmit FIFO empty.
        cyc("R6", 5'b0, 5'b0, 1'b1, 8'h02, 1'b0, 1'b1, 1'b0, 1'b1);
        @(negedge clk); #1 check("R6", iir_rdata, 8'hC1);
        cyc("R6", 5'b0, 5'b0, 1'b1, 8'h02, 1'b0, 1'b1, 1'b1, 1'b1);
        @(negedge clk); #1 check("R6", iir_rdata, 8'hC2);
        // R7: read showing rx leaves tx pending.
        cyc("R7", 5'b0, 5'b0, 1'b1, 8'h03, 1'b0, 1'b1, 1'b0, 1'b1);
        cyc("R7", 5'b00001, 5'b0, 1'b0, 8'h0, 1'b0, 1'b1, 1'b0, 1'b1);
        cyc("R7", 5'b0, 5'b0, 1'b0, 8'h0, 1'b1, 1'b1, 1'b0, 1'b1);
        cyc("R7", 5'b0, 5'b00001, 1'b0, 8'h0, 1'b0, 1'b1, 1'b0, 1'b1);
        @(negedge clk); #1 check("R7", iir_rdata, 8'hC2);
        // R10: collision keeps the flag set.
        cyc("R10", 5'b00100, 5'b00100, 1'b1, 8'h04, 1'b0, 1'b1, 1'b0, 1'b1);
        @(negedge clk); #1 check("R10", iir_rdata, 8'hC6);
        // R9: gate off hides the request.
        idle("R9", 1'b1, 1'b0);
        @(negedge clk); #1 check("R9", {6'b0, irq_oe, irq}, 8'h00);

        // Random mix compared against the model.
        for (int i = 0; i < 4000; i++) begin
            logic [4:0] s, c;
            logic w, rd;
            s  = (($urandom % 4) == 0) ? 5'($urandom) : 5'b0;
            c  = (($urandom % 3) == 0) ? 5'($urandom) : 5'b0;
            w  = (($urandom % 8) == 0);
            rd = (($urandom % 4) == 0);
            cyc("R3", s, c, w, 8'($urandom), rd, 1'($urandom),
                1'($urandom), (($urandom % 6) != 0));
        end

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule